// File: doc/BRIEF.md
# External Abort Routing Unit

This block sits between the error-reporting points of a processor's memory pipeline and the core's exception logic. Four origins can signal a failed access: instruction fetch, data access, translation table walk, and an explicit virtual-to-physical translation operation. Each origin presents a strobe together with a timing tag (synchronous or asynchronous) and a tag that marks the error as a cache parity error rather than a bus error. For walk errors, a further input says whether the walk served an instruction fetch.

Synchronous errors become a precise request on the next clock edge. This is a prefetch-abort request for fetches and for walks that served a fetch. It is a data-abort request for everything else. Asynchronous errors from any origin are collected into one pending flag. The flag behaves like an interrupt line: it is held back while the abort-mask input is 1 and is released as a data-abort request once the mask is 0 and no request is outstanding.

Every request carries a 5-bit fault-status code and a 2-bit origin tag. These stay fixed until the core acknowledges the request.

Top module: `ext_abort_router`

## Requirements
- R1: A synchronous strobe on the fetch origin (index 0), sampled while no request is outstanding, raises `pabt_req` after the next rising edge, with origin 2'd0 and status 5'h08, or 5'h19 when the parity tag is set.
- R2: A synchronous walk strobe (index 2) raises `pabt_req` when `walk_for_fetch` is 1 and `dabt_req` otherwise. The origin is 2'd2 and the status is 5'h0C, or 5'h19 for parity.
- R3: A synchronous strobe on the data origin (index 1) or the translation-operation origin (index 3) raises `dabt_req`, with origin 2'd1 or 2'd3 and status 5'h08, or 5'h19 for parity.
- R4: An asynchronous strobe from any origin is reported only as `dabt_req` with `abt_async` = 1, never as `pabt_req`. The status is 5'h16, or 5'h18 for parity. When the mask is 0 and the block is idle, the request appears after the second rising edge following the strobe.
- R5: While `abort_mask` is 1, no asynchronous request is raised and the abort stays pending. It is reported on the first rising edge that samples the mask at 0.
- R6: Pending asynchronous aborts are held in a single flag. Further asynchronous strobes that arrive while the flag is set are merged into it, so they produce no extra request. The reported origin and status are those of the first strobe.
- R7: Synchronous reporting ignores `abort_mask`. When a synchronous and an unmasked asynchronous abort arrive in the same cycle, the synchronous one is reported first and the asynchronous one follows after its acknowledge.
- R8: An outstanding request and its status, origin and async tag are held unchanged until `abort_ack` is sampled at 1. The request then drops on that edge. An acknowledge with no request outstanding has no effect.
- R9: A synchronous strobe that arrives while a request is outstanding is ignored.
- R10: When several synchronous strobes arrive in the same cycle, the lowest origin index is reported.
- R11: Reset clears both requests, the async tag, the status, the origin and the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_vld | input | 4 | Abort strobe per origin: 0 fetch, 1 data, 2 walk, 3 translation operation |
| src_async | input | 4 | Per-origin tag: 1 means the abort is asynchronous |
| src_parity | input | 4 | Per-origin tag: 1 means the error is a cache parity error |
| walk_for_fetch | input | 1 | 1 when the walk served an instruction fetch |
| abort_mask | input | 1 | Holds back asynchronous reporting while 1 |
| abort_ack | input | 1 | Core acknowledge of the outstanding request |
| pabt_req | output | 1 | Prefetch-abort exception request |
| dabt_req | output | 1 | Data-abort exception request |
| abt_async | output | 1 | 1 when the outstanding request is asynchronous |
| fault_status | output | 5 | Fault-status code of the outstanding request |
| fault_origin | output | 2 | Origin tag of the outstanding request |

## Verification
A synchronous result is due one rising edge after its strobe. An asynchronous result is due two edges after its strobe: one edge sets the pending flag and the next loads the request. A request released by clearing the mask is due on the edge that samples the mask low, and an acknowledge clears the outputs on the edge that samples it.

The bench drives every input just after a falling edge. It then counts exactly those rising edges before sampling on the following falling edge. This puts each check in the cycle where the result is due. Hold and merge checks sample again over several later cycles to confirm that nothing changed.

// File: rtl/abort_pkg.sv
package abort_pkg;
    localparam int NUM_SRC   = 4;
    localparam int FS_W      = 5;
    localparam int ORG_W     = $clog2(NUM_SRC);

    localparam int SRC_FETCH = 0;
    localparam int SRC_DATA  = 1;
    localparam int SRC_WALK  = 2;
    localparam int SRC_XLAT  = 3;

    localparam logic [FS_W-1:0] FS_SYNC_EXT  = 5'h08;
    localparam logic [FS_W-1:0] FS_WALK_EXT  = 5'h0C;
    localparam logic [FS_W-1:0] FS_ASYNC_EXT = 5'h16;
    localparam logic [FS_W-1:0] FS_PAR_SYNC  = 5'h19;
    localparam logic [FS_W-1:0] FS_PAR_ASYNC = 5'h18;

    typedef struct packed {
        logic             pabt;
        logic             dabt;
        logic             async_r;
        logic [FS_W-1:0]  fs;
        logic [ORG_W-1:0] org;
    } report_t;

    typedef struct packed {
        logic             pend;
        logic [FS_W-1:0]  fs;
        logic [ORG_W-1:0] org;
    } pend_t;
endpackage

// File: rtl/abort_classifier.sv
module abort_classifier
    import abort_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_vld,
    input  logic [NUM_SRC-1:0] src_async,
    input  logic [NUM_SRC-1:0] src_parity,
    input  logic               walk_for_fetch,
    output logic               sync_hit,
    output report_t            sync_rpt,
    output logic               async_hit,
    output logic [FS_W-1:0]    async_fs,
    output logic [ORG_W-1:0]   async_org
);
    logic [NUM_SRC-1:0] is_sync;
    logic [NUM_SRC-1:0] is_async;
    logic [NUM_SRC-1:0] to_pabt;
    logic [FS_W-1:0]    fs_sync  [NUM_SRC];
    logic [FS_W-1:0]    fs_async [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam bit IS_FETCH = (g == SRC_FETCH);
        localparam bit IS_WALK  = (g == SRC_WALK);
        assign is_sync[g]  = src_vld[g] & ~src_async[g];
        assign is_async[g] = src_vld[g] &  src_async[g];
        assign to_pabt[g]  = IS_FETCH | (IS_WALK & walk_for_fetch);
        assign fs_sync[g]  = src_parity[g] ? FS_PAR_SYNC
                           : (IS_WALK ? FS_WALK_EXT : FS_SYNC_EXT);
        assign fs_async[g] = src_parity[g] ? FS_PAR_ASYNC : FS_ASYNC_EXT;
    end

    assign sync_hit  = |is_sync;
    assign async_hit = |is_async;

    // lowest origin index wins: scan downward so the last hit stands
    always_comb begin
        sync_rpt  = '0;
        async_fs  = '0;
        async_org = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (is_sync[i]) begin
                sync_rpt.pabt    = to_pabt[i];
                sync_rpt.dabt    = ~to_pabt[i];
                sync_rpt.async_r = 1'b0;
                sync_rpt.fs      = fs_sync[i];
                sync_rpt.org     = ORG_W'(i);
            end
            if (is_async[i]) begin
                async_fs  = fs_async[i];
                async_org = ORG_W'(i);
            end
        end
    end
endmodule

// File: rtl/abort_pending.sv
module abort_pending
    import abort_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             async_hit,
    input  logic [FS_W-1:0]  async_fs,
    input  logic [ORG_W-1:0] async_org,
    input  logic             clr,
    output pend_t            pend
);
    pend_t pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr) begin
            pend_d.pend = 1'b0;
        end
        // a set while still pending (and not being cleared) merges
        if (async_hit && !(pend_q.pend && !clr)) begin
            pend_d.pend = 1'b1;
            pend_d.fs   = async_fs;
            pend_d.org  = async_org;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/abort_reporter.sv
module abort_reporter
    import abort_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sync_hit,
    input  report_t sync_rpt,
    input  pend_t   pend,
    input  logic    abort_mask,
    input  logic    abort_ack,
    output report_t rpt,
    output logic    async_done
);
    report_t rpt_d, rpt_q;
    logic    active_q;

    assign active_q = rpt_q.pabt | rpt_q.dabt;

    always_comb begin
        rpt_d = rpt_q;
        if (active_q) begin
            if (abort_ack) begin
                rpt_d = '0;
            end
        end else if (sync_hit) begin
            rpt_d = sync_rpt;
        end else if (pend.pend && !abort_mask) begin
            rpt_d.pabt    = 1'b0;
            rpt_d.dabt    = 1'b1;
            rpt_d.async_r = 1'b1;
            rpt_d.fs      = pend.fs;
            rpt_d.org     = pend.org;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rpt_q <= '0;
        end else begin
            rpt_q <= rpt_d;
        end
    end

    assign rpt        = rpt_q;
    assign async_done = active_q & abort_ack & rpt_q.async_r;
endmodule

// File: rtl/ext_abort_router.sv
module ext_abort_router
    import abort_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_vld,
    input  logic [NUM_SRC-1:0] src_async,
    input  logic [NUM_SRC-1:0] src_parity,
    input  logic               walk_for_fetch,
    input  logic               abort_mask,
    input  logic               abort_ack,
    output logic               pabt_req,
    output logic               dabt_req,
    output logic               abt_async,
    output logic [FS_W-1:0]    fault_status,
    output logic [ORG_W-1:0]   fault_origin
);
    logic             sync_hit;
    report_t          sync_rpt;
    logic             async_hit;
    logic [FS_W-1:0]  async_fs;
    logic [ORG_W-1:0] async_org;
    logic             async_done;
    pend_t            pend;
    report_t          rpt;

    abort_classifier u_class (
        .src_vld        (src_vld),
        .src_async      (src_async),
        .src_parity     (src_parity),
        .walk_for_fetch (walk_for_fetch),
        .sync_hit       (sync_hit),
        .sync_rpt       (sync_rpt),
        .async_hit      (async_hit),
        .async_fs       (async_fs),
        .async_org      (async_org)
    );

    abort_pending u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_hit (async_hit),
        .async_fs  (async_fs),
        .async_org (async_org),
        .clr       (async_done),
        .pend      (pend)
    );

    abort_reporter u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_hit   (sync_hit),
        .sync_rpt   (sync_rpt),
        .pend       (pend),
        .abort_mask (abort_mask),
        .abort_ack  (abort_ack),
        .rpt        (rpt),
        .async_done (async_done)
    );

    assign pabt_req     = rpt.pabt;
    assign dabt_req     = rpt.dabt;
    assign abt_async    = rpt.async_r;
    assign fault_status = rpt.fs;
    assign fault_origin = rpt.org;
endmodule

// File: rtl/ext_abort_router_chk.sv
module ext_abort_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_vld,
    input logic       fetch_async,
    input logic       abort_mask,
    input logic       abort_ack,
    input logic       pabt_req,
    input logic       dabt_req,
    input logic       abt_async,
    input logic [4:0] fault_status,
    input logic [1:0] fault_origin
);
    AST_SYNC_FETCH_PABT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pabt_req && !dabt_req && fetch_vld && !fetch_async) |=> (pabt_req && fault_origin == 2'd0)); // R1

    AST_ASYNC_NEVER_PABT: assert property (@(posedge clk) disable iff (!rst_n)
        pabt_req |-> !abt_async); // R4

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pabt_req, dabt_req})); // R4

    AST_MASK_GATES_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dabt_req) && abt_async) |-> !$past(abort_mask)); // R5

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((pabt_req || dabt_req) && !abort_ack)
        |=> $stable({pabt_req, dabt_req, abt_async, fault_status, fault_origin})); // R8

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((pabt_req || dabt_req) && abort_ack) |=> !(pabt_req || dabt_req)); // R8
endmodule

bind ext_abort_router ext_abort_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_vld    (src_vld[0]),
    .fetch_async  (src_async[0]),
    .abort_mask   (abort_mask),
    .abort_ack    (abort_ack),
    .pabt_req     (pabt_req),
    .dabt_req     (dabt_req),
    .abt_async    (abt_async),
    .fault_status (fault_status),
    .fault_origin (fault_origin)
);

// File: tb/ext_abort_router_bench.sv
module ext_abort_router_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_vld = '0, src_async = '0, src_parity = '0;
    logic       walk_for_fetch = 1'b0, abort_mask = 1'b0, abort_ack = 1'b0;
    logic       pabt_req, dabt_req, abt_async;
    logic [4:0] fault_status;
    logic [1:0] fault_origin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ext_abort_router u_ext_abort_router (
        .clk (clk), .rst_n (rst_n), .src_vld (src_vld), .src_async (src_async),
        .src_parity (src_parity), .walk_for_fetch (walk_for_fetch),
        .abort_mask (abort_mask), .abort_ack (abort_ack), .pabt_req (pabt_req),
        .dabt_req (dabt_req), .abt_async (abt_async), .fault_status (fault_status),
        .fault_origin (fault_origin)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [3:0] vld;
        logic [3:0] asy;
        logic [3:0] par;
        logic       wff;
        logic       two;
        logic [9:0] exp;
    } vec_t;

    // exp = {pabt, dabt, async, status[4:0], origin[1:0]}
    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, {3'b100, 5'h08, 2'd0}},
        '{4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b0, {3'b100, 5'h19, 2'd0}},
        '{4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b0, {3'b010, 5'h08, 2'd1}},
        '{4'b0100, 4'b0000, 4'b0000, 1'b1, 1'b0, {3'b100, 5'h0C, 2'd2}},
        '{4'b0100, 4'b0000, 4'b0000, 1'b0, 1'b0, {3'b010, 5'h0C, 2'd2}},
        '{4'b1000, 4'b0000, 4'b0000, 1'b0, 1'b0, {3'b010, 5'h08, 2'd3}},
        '{4'b1000, 4'b1000, 4'b0000, 1'b0, 1'b1, {3'b011, 5'h16, 2'd3}},
        '{4'b0001, 4'b0001, 4'b0000, 1'b0, 1'b1, {3'b011, 5'h16, 2'd0}},
        '{4'b0010, 4'b0010, 4'b0010, 1'b0, 1'b1, {3'b011, 5'h18, 2'd1}},
        '{4'b1110, 4'b0000, 4'b0000, 1'b0, 1'b0, {3'b010, 5'h08, 2'd1}},
        '{4'b0100, 4'b0000, 4'b0100, 1'b1, 1'b0, {3'b100, 5'h19, 2'd2}}
    };
    localparam string TAG [NV] = '{"R1", "R1", "R3", "R2", "R2", "R3",
                                   "R4", "R4", "R4", "R10", "R2"};

    function automatic logic [9:0] outs();
        return {pabt_req, dabt_req, abt_async, fault_status, fault_origin};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [9:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic strobe(logic [3:0] v, logic [3:0] a, logic [3:0] p, logic w);
        src_vld = v; src_async = a; src_parity = p; walk_for_fetch = w;
        tick();
        src_vld = '0; src_async = '0; src_parity = '0; walk_for_fetch = 1'b0;
    endtask

    task automatic ack();
        abort_ack = 1'b1;
        tick();
        abort_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        check("R11 reset", '0);
        rst_n = 1'b1;
        tick();
        check("R11 after reset", '0);

        // vector table: R1 R2 R3 R4 R10
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i].vld, VEC[i].asy, VEC[i].par, VEC[i].wff);
            if (VEC[i].two) tick();
            check(TAG[i], VEC[i].exp);
            ack();
            check("R8 ack clears", '0);
        end

        // R5 mask holds async, then release
        abort_mask = 1'b1;
        strobe(4'b0010, 4'b0010, 4'b0000, 1'b0);
        // R6 second async merges into the flag
        strobe(4'b0001, 4'b0001, 4'b0001, 1'b0);
        tick(); tick(); tick();
        check("R5 masked", '0);
        abort_mask = 1'b0;
        tick();
        check("R5 released / R6 first info", {3'b011, 5'h16, 2'd1});
        ack();
        tick(); tick();
        check("R6 merged no second report", '0);

        // R7 sync not blocked by mask
        abort_mask = 1'b1;
        strobe(4'b0001, 4'b0000, 4'b0000, 1'b0);
        check("R7 sync under mask", {3'b100, 5'h08, 2'd0});
        ack();
        abort_mask = 1'b0;

        // R7 same cycle sync and async: sync first
        strobe(4'b0011, 4'b0010, 4'b0000, 1'b0);
        check("R7 sync first", {3'b100, 5'h08, 2'd0});
        ack();
        check("R7 gap after ack", '0);
        tick();
        check("R7 async follows", {3'b011, 5'h16, 2'd1});
        ack();
        tick();
        check("R7 no repeat", '0);

        // R9 sync while busy ignored; R8 hold
        strobe(4'b0001, 4'b0000, 4'b0000, 1'b0);
        strobe(4'b0010, 4'b0000, 4'b0000, 1'b0);
        tick(); tick();
        check("R9 R8 held", {3'b100, 5'h08, 2'd0});
        ack();
        tick();
        check("R9 dropped strobe", '0);

        // R8 ack with nothing outstanding
        ack();
        check("R8 idle ack", '0);
        abort_mask = 1'b1;
        strobe(4'b0100, 4'b0100, 4'b0000, 1'b0);
        ack();
        abort_mask = 1'b0;
        tick();
        check("R8 idle ack keeps pending", {3'b011, 5'h16, 2'd2});
        ack();

        // R11 reset clears pending
        abort_mask = 1'b1;
        strobe(4'b1000, 4'b1000, 4'b0000, 1'b0);
        rst_n = 1'b0;
        tick();
        check("R11 in reset", '0);
        rst_n = 1'b1;
        abort_mask = 1'b0;
        tick(); tick();
        check("R11 pending cleared", '0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule